// File: doc/BRIEF.md
# Saturating Timer Tick Counter

This block derives a periodic timer tick from video scan timing and keeps a count of ticks that the CPU has not yet serviced. A flyback-start strobe sets the tick phase. The first tick falls on the second scan line after that strobe. After it, one tick falls on every 52nd line until the next flyback restarts the sequence. With 64 µs lines this gives a 3.328 ms period at either frame rate.

A tick does not reach the count at once. It waits in a pending flag until an instruction-fetch (M1) strobe latches it into a synchroniser stage. The next M1 strobe then adds it to a 4-bit count, which stops at fifteen. The CPU reads the count through an 8-bit data port, and the read clears it. A level interrupt request stays high while the count is nonzero. A tick that sits in the synchroniser stage when a read happens was latched by the fetch of the read instruction, and the read discards it. This reproduces a defined lost-tick case.

Top module: `tick_count_unit`

## Requirements
- R1: After a flyback-start strobe, a tick is produced on the 2nd line strobe that follows it, and then on every 52nd line strobe after that, until the next flyback-start strobe. A line strobe in the same cycle as a flyback-start strobe is not counted.
- R2: A tick reaches the count at the second M1 strobe after it. The first M1 strobe latches the tick, and the second one increments the count. The count is visible in the cycle after that second strobe.
- R3: The count stops at 15 and never wraps to 0.
- R4: In the cycle of a read strobe, rd_data carries the count in bits 3..0 and zero in bits 7..4. From the next cycle on, the count is 0.
- R5: irq is high exactly when the count is nonzero.
- R6: A read strobe discards a tick that an M1 strobe has latched but not yet counted. A tick that no M1 strobe has latched yet survives the read and is counted later. When a read and an increment fall in the same cycle, the read wins.
- R7: Reset clears the count, irq and the tick phase. No tick is produced after reset until the first flyback-start strobe.
- R8: The count changes only in a cycle with an M1 strobe or a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_stb | input | 1 | One-cycle strobe per scan line |
| fly_start | input | 1 | One-cycle strobe at the start of frame flyback |
| m1_stb | input | 1 | One-cycle strobe per CPU instruction fetch |
| rd_stb | input | 1 | One-cycle CPU read strobe of the counter port |
| rd_data | output | 8 | Count in bits 3..0, zeros above |
| irq | output | 1 | Level interrupt request |

## Verification
Each result has a fixed latency:
- A tick appears one cycle after the line strobe that completes its interval. It counts as latched when an M1 strobe falls in or after that cycle.
- The count rises in the cycle after the second M1 edge.
- A read shows the old count during its own cycle and 0 from the next cycle on.
- irq follows the count with no further delay.

The bench drives every input at the falling edge and compares rd_data and irq at the next falling edge against a transaction-level model. Directed sequences place M1 strobes and reads one cycle at a time around a tick, so each of these latencies is checked exactly.

// File: rtl/tick_pkg.sv
package tick_pkg;
  parameter int CNT_W        = 4;
  parameter int RD_W         = 8;
  parameter int LEAD_LINES   = 2;
  parameter int PERIOD_LINES = 52;
endpackage

// File: rtl/tick_phase_gen.sv
module tick_phase_gen #(
  parameter int LEAD   = 2,
  parameter int PERIOD = 52
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic fly_start,
  output logic tick
);
  localparam int LW = $clog2(PERIOD + 1);
  localparam logic [LW-1:0] LEAD_V = LW'(LEAD);
  localparam logic [LW-1:0] PER_V  = LW'(PERIOD);
  localparam logic [LW-1:0] ONE_V  = LW'(1);

  // lines remaining to next tick; zero means idle until a flyback
  logic [LW-1:0] left_q, left_d;
  logic          tick_d;

  always_comb begin
    left_d = left_q;
    tick_d = 1'b0;
    if (fly_start) begin
      left_d = LEAD_V;
    end else if (line_stb && (left_q != '0)) begin
      if (left_q == ONE_V) begin
        tick_d = 1'b1;
        left_d = PER_V;
      end else begin
        left_d = left_q - ONE_V;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      tick   <= 1'b0;
    end else begin
      left_q <= left_d;
      tick   <= tick_d;
    end
  end
endmodule

// File: rtl/tick_m1_sync.sv
module tick_m1_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic m1_stb,
  input  logic rd_stb,
  output logic inc
);
  logic pend_q, pend_d;
  logic stg_q, stg_d;
  logic arrive;

  assign arrive = pend_q | tick;

  always_comb begin
    pend_d = m1_stb ? 1'b0 : arrive;
    if (m1_stb)      stg_d = arrive;
    else if (rd_stb) stg_d = 1'b0;   // token latched by the read's fetch is dropped
    else             stg_d = stg_q;
  end

  assign inc = m1_stb & stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stg_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      stg_q  <= stg_d;
    end
  end
endmodule

// File: rtl/tick_sat_count.sv
module tick_sat_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAX_V = '1;
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt != MAX_V));
    cnt_d  = clr ? '0 : cnt + ONE_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/tick_count_unit.sv
module tick_count_unit
  import tick_pkg::*;
#(
  parameter int CNT_W_P  = CNT_W,
  parameter int RD_W_P   = RD_W,
  parameter int LEAD_P   = LEAD_LINES,
  parameter int PERIOD_P = PERIOD_LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              fly_start,
  input  logic              m1_stb,
  input  logic              rd_stb,
  output logic [RD_W_P-1:0] rd_data,
  output logic              irq
);
  localparam int PAD_W = RD_W_P - CNT_W_P;

  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic               tick_q;
  logic               inc;
  logic [CNT_W_P-1:0] cnt;

  tick_phase_gen #(.LEAD(LEAD_P), .PERIOD(PERIOD_P)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .line_stb(line_stb),
    .fly_start(fly_start), .tick(tick_q)
  );

  tick_m1_sync u_sync (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick_q),
    .m1_stb(m1_stb), .rd_stb(rd_stb), .inc(inc)
  );

  tick_sat_count #(.CNT_W(CNT_W_P)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .inc(inc), .clr(rd_stb), .cnt(cnt)
  );

  assign rd_data = {{PAD_W{1'b0}}, cnt};
  assign irq     = |cnt;
endmodule

// File: rtl/tick_count_chk.sv
module tick_count_chk #(
  parameter int CNT_W = 4,
  parameter int RD_W  = 8
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            line_stb,
  input logic            m1_stb,
  input logic            rd_stb,
  input logic            tick,
  input logic            irq,
  input logic [RD_W-1:0] rd_data
);
  logic [CNT_W-1:0] c;
  assign c = rd_data[CNT_W-1:0];

  assert_tick_on_line_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    tick |-> $past(line_stb));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_stb |=> (c == $past(c)) || (c == $past(c) + CNT_W'(1)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    ((c == '1) && !rd_stb) |=> (c == '1));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    rd_stb |=> (c == '0));

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    irq == (c != '0));

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_stb && m1_stb) |=> !irq);

  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (!rd_stb && !m1_stb) |=> $stable(c));
endmodule

bind tick_count_unit tick_count_chk #(.CNT_W(CNT_W_P), .RD_W(RD_W_P)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .line_stb(line_stb), .m1_stb(m1_stb),
  .rd_stb(rd_stb), .tick(tick_q), .irq(irq), .rd_data(rd_data)
);

// File: tb/test_tick_count_unit.sv
module test_tick_count_unit;
  import tick_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, line_stb, fly_start, m1_stb, rd_stb;
  logic [RD_W-1:0] rd_data;
  logic            irq;

  int checks = 0, failures = 0;

  int m_left, m_cnt;
  bit m_tick, m_pend, m_stg;

  tick_count_unit i_tick_count_unit (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .fly_start(fly_start),
    .m1_stb(m1_stb), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_left = 0; m_cnt = 0; m_tick = 0; m_pend = 0; m_stg = 0;
  endtask

  function automatic int sat_inc(int c);
    return (c >= 15) ? 15 : c + 1;
  endfunction

  // one clock: drive at falling edge, compare, advance model, wait to next falling edge
  task automatic cyc(bit l, bit f, bit m, bit r);
    bit arrive, tick_n;
    int left_n;
    line_stb = l; fly_start = f; m1_stb = m; rd_stb = r;
    check(rd_data == RD_W'(m_cnt), "R8 count track", rd_data, m_cnt);
    check(irq == (m_cnt != 0), "R5 irq level", irq, m_cnt != 0);
    if (!rst_n) model_reset();
    else begin
      tick_n = 0; left_n = m_left;
      if (f) left_n = LEAD_LINES;
      else if (l && m_left != 0) begin
        if (m_left == 1) begin tick_n = 1; left_n = PERIOD_LINES; end
        else left_n = m_left - 1;
      end
      arrive = m_pend | m_tick;
      if (r) m_cnt = 0;
      else if (m && m_stg) m_cnt = sat_inc(m_cnt);
      if (m) m_stg = arrive; else if (r) m_stg = 0;
      m_pend = m ? 1'b0 : arrive;
      m_tick = tick_n; m_left = left_n;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask
  task automatic lines(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask
  task automatic m1x2();
    cyc(0, 0, 1, 0); cyc(0, 0, 1, 0);
  endtask
  task automatic expect_cnt(int e, string req);
    check(rd_data == RD_W'(e), req, rd_data, e);
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; line_stb = 0; fly_start = 0; m1_stb = 0; rd_stb = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    expect_cnt(0, "R7 reset count");
    check(irq == 0, "R7 reset irq", irq, 0);
    rst_n = 1;
    idle(4);

    // R7: no tick before first flyback
    lines(60); m1x2();
    expect_cnt(0, "R7 no tick before flyback");

    // R1/R2 tick placement and M1 latency
    cyc(0, 1, 0, 0); lines(1); m1x2();
    expect_cnt(0, "R1 one line is not enough");
    lines(1); cyc(0, 0, 1, 0);
    expect_cnt(0, "R2 first M1 only latches");
    cyc(0, 0, 1, 0);
    expect_cnt(1, "R2 second M1 counts");
    lines(51); m1x2();
    expect_cnt(1, "R1 51 lines no tick");
    lines(1); m1x2();
    expect_cnt(2, "R1 52nd line ticks");

    // R1: flyback coinciding with a line strobe
    cyc(1, 1, 0, 0); lines(1); m1x2();
    expect_cnt(2, "R1 coincident line not counted");
    lines(1); m1x2();
    expect_cnt(3, "R1 tick after coincident flyback");

    // R3 saturation
    for (int i = 0; i < 16; i++) begin
      cyc(0, 1, 0, 0); lines(2); m1x2();
    end
    expect_cnt(15, "R3 saturates at 15");
    check(irq == 1, "R5 irq high", irq, 1);

    // R4 read
    rd_stb = 1;
    check(rd_data == 8'h0F, "R4 read value and upper zero", rd_data, 15);
    cyc(0, 0, 0, 1);
    expect_cnt(0, "R4 cleared after read");
    check(irq == 0, "R5 irq low after read", irq, 0);

    // R6 lost tick: latched by the read's M1
    cyc(0, 1, 0, 0); lines(2); cyc(0, 0, 1, 0); cyc(0, 0, 0, 1); m1x2();
    expect_cnt(0, "R6 latched tick lost on read");
    // R6 tick not yet latched survives
    cyc(0, 1, 0, 0); lines(2); idle(1); cyc(0, 0, 0, 1); m1x2();
    expect_cnt(1, "R6 pending tick survives read");
    cyc(0, 0, 0, 1);
    // R6 clear beats simultaneous increment
    cyc(0, 1, 0, 0); lines(2); cyc(0, 0, 1, 0); cyc(0, 0, 1, 1);
    expect_cnt(0, "R6 clear wins over increment");
    m1x2();
    expect_cnt(0, "R6 token gone after clash");

    // R8: lines and flyback alone do not move the count
    cyc(0, 1, 0, 0); lines(2); m1x2();
    expect_cnt(1, "R8 setup");
    cyc(0, 1, 0, 0); lines(60);
    expect_cnt(1, "R8 no change without M1");

    // R7 reset mid-run
    rst_n = 0; @(negedge clk);
    expect_cnt(0, "R7 async clear");
    model_reset();
    idle(2); rst_n = 1; idle(4);
    lines(120); m1x2();
    expect_cnt(0, "R7 phase cleared by reset");

    // random traffic against the model
    begin
      int ph, ln, flen, fpos;
      bit l, f, m, r;
      void'($urandom(32'h5EED1234));
      ph = 0; ln = 0; flen = 312; fpos = 2;
      for (int i = 0; i < 9000; i++) begin
        l = (ph == 0);
        f = (ln == 0) && (ph == fpos);
        m = ($urandom % 3) == 0;
        r = ($urandom % 40) == 0;
        cyc(l, f, m, r);
        ph = (ph + 1) % 5;
        if (ph == 0) begin
          ln = ln + 1;
          if (ln == flen) begin
            ln = 0;
            flen = (flen == 312) ? 262 : 312;
            fpos = $urandom % 2 == 0 ? 0 : 2;
          end
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule